// File: doc/BRIEF.md
# Translation Unit Control and Fault Registers

This block is the software-visible control face of an address translation unit. A 32-bit register bus sets the translation table base pointer, the translation enable, the exception enable and an out-of-bound enable. The block drives them to the translation logic as plain level outputs. The flush command register turns a rising command bit into a one-cycle TLB flush strobe.

The table walker reports faults with a valid strobe, a three-bit cause and the offending address. While translation is on, the block ORs each cause into a sticky status register. It keeps the address of the first fault that arrives while status is clear, and it raises the interrupt line while any cause is pending. Software reads the address, then writes a value with a zero cause field to the status register. This drops every pending cause and the interrupt. The usual bring-up order is: base pointer, out-of-bound enable, exception enable, translation enable, then a flush.

Top module: `iommu_ctl_regs`

## Requirements
- R1: After a synchronous reset, every configuration output, flush_pulse, irq and bus_rdata is 0, and every register reads back as 0.
- R2: A write to offset 0x38C stores all 32 bits as the table base pointer. The value drives table_base from the cycle after the write and reads back unchanged.
- R3: Bit 0 of a write to offset 0x388 sets xlat_en, so writing 0 disables translation. A read of 0x388 returns only bit 0.
- R4: Bit 28 of a write to offset 0x1AC sets oob_en. A read of 0x1AC returns only bit 28.
- R5: Bit 0 of a write to offset 0x380 sets exc_en. A read of 0x380 returns the captured fault address, not the written value.
- R6: The flush command is bit 4 at offset 0x184. When a write sets it while the stored bit is 0, flush_pulse is high for exactly the one cycle after the write. A write of 1 while the stored bit is already 1 gives no pulse. A read returns the stored bit in position 4.
- R7: A fault report with a nonzero cause, made while xlat_en is 1, ORs the cause into status bits [2:0] at offset 0x384. irq is high from the next cycle while any of those bits is set.
- R8: The fault address register loads only when a fault is accepted while status is zero. Later faults add cause bits but leave the address unchanged.
- R9: A write to 0x384 whose bits [2:0] are all zero clears every status bit, and irq falls the cycle after. A write with any of those bits set changes nothing. A fault accepted in the same cycle as a clear becomes the new, first fault.
- R10: While xlat_en is 0, fault reports change neither status nor the fault address. Flush writes still give their pulse.
- R11: Reads of any other offset return 0. Writes to them change no register or output.
- R12: Read data appears on bus_rdata in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| flt_valid | input | 1 | Fault report strobe from the walker |
| flt_cause | input | 3 | Fault cause bits |
| flt_addr | input | 32 | Faulting address |
| xlat_en | output | 1 | Translation enable |
| exc_en | output | 1 | Exception enable |
| oob_en | output | 1 | Out-of-bound check enable |
| table_base | output | 32 | Translation table base pointer |
| flush_pulse | output | 1 | One-cycle TLB flush strobe |
| irq | output | 1 | Interrupt, high while any fault cause is pending |

## Verification
Directed sequences run the full bring-up order. They write all-ones patterns so that stray bits in the narrow fields show up. They repeat flush writes of 1, 1, 0, 1 to tell edge detection from level detection. They also cover a fault and a clear landing in the same cycle. A seeded random mix of faults with random causes, including cause zero, clears with zero and nonzero cause fields, and enable toggles runs against a bench model. This mix separates first-fault address capture from last-fault capture, shows whether the fault gate follows translation enable, and shows whether status accumulates by OR or by overwrite.

// File: rtl/iommu_ctl_pkg.sv
package iommu_ctl_pkg;
  localparam int NUM_REGS = 6;
  typedef enum int {
    IX_FLUSH = 0, IX_OOB = 1, IX_FADDR = 2, IX_STAT = 3, IX_CTRL = 4, IX_BASE = 5
  } reg_ix_e;
  localparam logic [11:0] OFS_FLUSH = 12'h184;
  localparam logic [11:0] OFS_OOB   = 12'h1AC;
  localparam logic [11:0] OFS_FADDR = 12'h380;
  localparam logic [11:0] OFS_STAT  = 12'h384;
  localparam logic [11:0] OFS_CTRL  = 12'h388;
  localparam logic [11:0] OFS_BASE  = 12'h38C;
  localparam int FLUSH_BIT = 4;
  localparam int OOB_BIT   = 28;

  function automatic logic [11:0] reg_offset(input int ix);
    case (ix)
      IX_FLUSH: reg_offset = OFS_FLUSH;
      IX_OOB:   reg_offset = OFS_OOB;
      IX_FADDR: reg_offset = OFS_FADDR;
      IX_STAT:  reg_offset = OFS_STAT;
      IX_CTRL:  reg_offset = OFS_CTRL;
      default:  reg_offset = OFS_BASE;
    endcase
  endfunction
endpackage

// File: rtl/iommu_ctl_decode.sv
module iommu_ctl_decode
  import iommu_ctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] sel
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(reg_offset(i)));
  end
endmodule

// File: rtl/iommu_ctl_flush.sv
module iommu_ctl_flush (
  input  logic clk,
  input  logic rst,
  input  logic cmd_wr,
  input  logic cmd_bit,
  output logic cmd_q,
  output logic flush_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q       <= 1'b0;
      flush_pulse <= 1'b0;
    end else begin
      flush_pulse <= cmd_wr && cmd_bit && !cmd_q;
      if (cmd_wr) cmd_q <= cmd_bit;
    end
  end
endmodule

// File: rtl/iommu_ctl_fault.sv
module iommu_ctl_fault #(
  parameter int CAUSE_W = 3,
  parameter int FA_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic               flt_valid,
  input  logic [CAUSE_W-1:0] flt_cause,
  input  logic [FA_W-1:0]    flt_addr,
  input  logic               clr,
  output logic [CAUSE_W-1:0] status_q,
  output logic [FA_W-1:0]    addr_q,
  output logic               irq
);
  logic [CAUSE_W-1:0] base_st;
  logic [CAUSE_W-1:0] next_st;
  logic               hit;

  always_comb begin
    base_st = clr ? '0 : status_q;
    hit     = accept && flt_valid && (|flt_cause);
    next_st = base_st | (hit ? flt_cause : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      addr_q   <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= next_st;
      irq      <= |next_st;
      if (hit && base_st == '0) addr_q <= flt_addr;
    end
  end
endmodule

// File: rtl/iommu_ctl_regs.sv
module iommu_ctl_regs
  import iommu_ctl_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 3,
  parameter int FA_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               flt_valid,
  input  logic [CAUSE_W-1:0] flt_cause,
  input  logic [FA_W-1:0]    flt_addr,
  output logic               xlat_en,
  output logic               exc_en,
  output logic               oob_en,
  output logic [DATA_W-1:0]  table_base,
  output logic               flush_pulse,
  output logic               irq
);
  logic [NUM_REGS-1:0] sel;
  logic [NUM_REGS-1:0] wsel;
  logic                flush_q;
  logic [CAUSE_W-1:0]  status_q;
  logic [FA_W-1:0]     fault_addr_q;
  logic [DATA_W-1:0]   rd_mux;

  iommu_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));
  assign wsel = bus_wr ? sel : '0;

  iommu_ctl_flush u_flush (
    .clk(clk), .rst(rst), .cmd_wr(wsel[IX_FLUSH]), .cmd_bit(bus_wdata[FLUSH_BIT]),
    .cmd_q(flush_q), .flush_pulse(flush_pulse)
  );

  iommu_ctl_fault #(.CAUSE_W(CAUSE_W), .FA_W(FA_W)) u_fault (
    .clk(clk), .rst(rst), .accept(xlat_en), .flt_valid(flt_valid),
    .flt_cause(flt_cause), .flt_addr(flt_addr),
    .clr(wsel[IX_STAT] && (bus_wdata[CAUSE_W-1:0] == '0)),
    .status_q(status_q), .addr_q(fault_addr_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xlat_en    <= 1'b0;
      exc_en     <= 1'b0;
      oob_en     <= 1'b0;
      table_base <= '0;
    end else begin
      if (wsel[IX_CTRL])  xlat_en    <= bus_wdata[0];
      if (wsel[IX_FADDR]) exc_en     <= bus_wdata[0];
      if (wsel[IX_OOB])   oob_en     <= bus_wdata[OOB_BIT];
      if (wsel[IX_BASE])  table_base <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel[IX_FLUSH]: rd_mux[FLUSH_BIT] = flush_q;
      sel[IX_OOB]:   rd_mux[OOB_BIT]   = oob_en;
      sel[IX_FADDR]: rd_mux            = DATA_W'(fault_addr_q);
      sel[IX_STAT]:  rd_mux            = DATA_W'(status_q);
      sel[IX_CTRL]:  rd_mux[0]         = xlat_en;
      sel[IX_BASE]:  rd_mux            = table_base;
      default:       rd_mux            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/iommu_ctl_regs_chk.sv
module iommu_ctl_regs_chk
  import iommu_ctl_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 3,
  parameter int FA_W    = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               flt_valid,
  input logic [CAUSE_W-1:0] flt_cause,
  input logic               xlat_en,
  input logic               flush_pulse,
  input logic               irq,
  input logic [FA_W-1:0]    fault_addr_q
);
  logic wr_flush1, wr_clear, accepted;
  assign wr_flush1 = bus_wr && bus_addr == ADDR_W'(OFS_FLUSH) && bus_wdata[FLUSH_BIT];
  assign wr_clear  = bus_wr && bus_addr == ADDR_W'(OFS_STAT) && bus_wdata[CAUSE_W-1:0] == '0;
  assign accepted  = xlat_en && flt_valid && (|flt_cause);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!irq && !flush_pulse && !xlat_en));

  assert_flush_single_R6: assert property (@(posedge clk) disable iff (rst)
    flush_pulse |=> !flush_pulse);

  assert_flush_cause_R6: assert property (@(posedge clk) disable iff (rst)
    flush_pulse |-> $past(wr_flush1));

  assert_fault_raises_irq_R7: assert property (@(posedge clk) disable iff (rst)
    accepted |=> irq);

  assert_first_addr_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (irq && !wr_clear) |=> $stable(fault_addr_q));

  assert_clear_drops_irq_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_clear && !accepted) |=> !irq);

  assert_disabled_ignores_R10: assert property (@(posedge clk) disable iff (rst)
    (!xlat_en && !irq) |=> !irq);
endmodule

bind iommu_ctl_regs iommu_ctl_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W), .FA_W(FA_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .flt_valid(flt_valid), .flt_cause(flt_cause), .xlat_en(xlat_en),
  .flush_pulse(flush_pulse), .irq(irq), .fault_addr_q(fault_addr_q)
);

// File: tb/iommu_ctl_regs_test.sv
`timescale 1ns/1ps
module iommu_ctl_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        flt_valid = 1'b0;
  logic [2:0]  flt_cause = '0;
  logic [31:0] flt_addr = '0;
  logic        xlat_en, exc_en, oob_en, flush_pulse, irq;
  logic [31:0] table_base;

  int errors = 0, checks = 0;
  logic [2:0]  m_st = '0;
  logic [31:0] m_fa = '0;
  logic        m_en = 1'b0;

  iommu_ctl_regs uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flt_valid(flt_valid),
    .flt_cause(flt_cause), .flt_addr(flt_addr), .xlat_en(xlat_en), .exc_en(exc_en),
    .oob_en(oob_en), .table_base(table_base), .flush_pulse(flush_pulse), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic fault(input logic [2:0] c, input logic [31:0] a);
    @(negedge clk); flt_valid = 1'b1; flt_cause = c; flt_addr = a;
    @(negedge clk); flt_valid = 1'b0;
  endtask

  function automatic logic [2:0] model_status(input logic [2:0] st, input logic en,
                                               input logic [2:0] c);
    return (en && c != 0) ? (st | c) : st;
  endfunction

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 outputs", {table_base[27:0], xlat_en, exc_en, oob_en, flush_pulse}, 0);
    check("R1 rdata", bus_rdata, 0);
    rd(12'h384, d); check("R1 status", d, 0);
    rd(12'h38C, d); check("R1 base", d, 0);

    // bring-up order; R2 R4 R5 R3
    wr(12'h38C, 32'hDEAD_B000);
    check("R2 table_base", table_base, 32'hDEAD_B000);
    rd(12'h38C, d); check("R2 readback", d, 32'hDEAD_B000);
    wr(12'h1AC, 32'hFFFF_FFFF);
    check("R4 oob_en", {31'd0, oob_en}, 1);
    rd(12'h1AC, d); check("R4 readback", d, 32'h1000_0000);
    wr(12'h380, 32'hFFFF_FFFF);
    check("R5 exc_en", {31'd0, exc_en}, 1);
    rd(12'h380, d); check("R5 read is fault addr", d, 0);
    wr(12'h388, 32'hFFFF_FFFF); m_en = 1'b1;
    check("R3 xlat_en", {31'd0, xlat_en}, 1);
    rd(12'h388, d); check("R3 readback", d, 1);

    // R6 flush edge behaviour
    wr(12'h184, 32'h10);
    check("R6 pulse", {31'd0, flush_pulse}, 1);
    @(negedge clk); check("R6 single cycle", {31'd0, flush_pulse}, 0);
    rd(12'h184, d); check("R6 readback", d, 32'h10);
    wr(12'h184, 32'hFFFF_FFFF);
    check("R6 no pulse when set", {31'd0, flush_pulse}, 0);
    wr(12'h184, 0);
    check("R6 no pulse on zero", {31'd0, flush_pulse}, 0);
    wr(12'h184, 32'h10);
    check("R6 pulse again", {31'd0, flush_pulse}, 1);
    wr(12'h184, 0);

    // R12 read holds
    rd(12'h38C, d);
    repeat (3) @(negedge clk);
    check("R12 hold", bus_rdata, 32'hDEAD_B000);

    // R7 R8 faults
    fault(3'b001, 32'hAAAA_0001);
    check("R7 irq", {31'd0, irq}, 1);
    fault(3'b100, 32'hBBBB_0002);
    rd(12'h384, d); check("R7 status OR", d, 32'h5);
    rd(12'h380, d); check("R8 first addr", d, 32'hAAAA_0001);
    fault(3'b000, 32'hCCCC_0003);
    rd(12'h384, d); check("R8 zero cause no effect", d, 32'h5);

    // R9 clear rules
    wr(12'h384, 32'hFFFF_FFF1);
    check("R9 nonzero write keeps irq", {31'd0, irq}, 1);
    wr(12'h384, 32'hFFFF_FFF8);
    check("R9 clear drops irq", {31'd0, irq}, 0);
    rd(12'h384, d); check("R9 status cleared", d, 0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'h384; bus_wdata = 0;
    flt_valid = 1'b1; flt_cause = 3'b010; flt_addr = 32'h1234_5678;
    @(negedge clk); bus_wr = 1'b0; flt_valid = 1'b0;
    check("R9 same-cycle fault wins", {31'd0, irq}, 1);
    rd(12'h380, d); check("R9 new first addr", d, 32'h1234_5678);
    wr(12'h384, 0);

    // R10 disabled
    wr(12'h388, 0); m_en = 1'b0;
    fault(3'b111, 32'h9999_0000);
    check("R10 irq stays low", {31'd0, irq}, 0);
    rd(12'h380, d); check("R10 addr unchanged", d, 32'h1234_5678);
    wr(12'h184, 32'h10);
    check("R10 flush still pulses", {31'd0, flush_pulse}, 1);
    wr(12'h184, 0);

    // R11 unmapped
    wr(12'h389, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h38D, 32'h0);
    check("R11 outputs unchanged", {table_base, 3'b0, xlat_en, exc_en, oob_en},
          {32'hDEAD_B000, 3'b0, 1'b0, 1'b1, 1'b1});
    rd(12'h389, d); check("R11 unmapped read", d, 0);
    rd(12'h390, d); check("R11 unmapped read 2", d, 0);

    // random mix against model (R7 R8 R9 R10)
    m_fa = 32'h1234_5678; m_st = '0;
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 5;
      case (op)
        0, 1: begin
          logic [2:0] c; logic [31:0] a; logic [2:0] ns;
          c = 3'($urandom); a = $urandom;
          ns = model_status(m_st, m_en, c);
          if (m_en && c != 0 && m_st == 0) m_fa = a;
          m_st = ns;
          fault(c, a);
        end
        2: begin
          logic [31:0] v;
          v = ($urandom % 2 == 0) ? ($urandom & 32'hFFFF_FFF8) : ($urandom | 32'h1);
          if (v[2:0] == 0) m_st = '0;
          wr(12'h384, v);
        end
        3: begin
          m_en = 1'($urandom);
          wr(12'h388, {31'd0, m_en});
        end
        default: begin
          rd(12'h384, d); check("R7 random status", d, {29'd0, m_st});
          rd(12'h380, d); check("R8 random addr", d, m_fa);
        end
      endcase
      check("R9 random irq", {31'd0, irq}, {31'd0, |m_st});
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule